// File: doc/BRIEF.md
# Flash Word Write Controller

This block sits between a byte-wide register bus and a word-organised, non-volatile memory array. Software, or a DMA engine acting for it, sets a byte count and a target word address. It then opens a write session and feeds bytes one at a time into a data register. The block joins each pair of bytes into a 16-bit word and starts one timed program operation per pair. After each word it moves the target address on by one, and the address carries across page boundaries.

While a word is being programmed, a busy status bit is set and the data register accepts nothing. Any read of the array during that time sets a sticky violation flag. A request line tells a DMA engine when the data register can take another byte, so a single-byte-per-request transfer paces itself. A behavioural array model with a parameterised program latency is part of the block, and it serves the read port.

Top module: `flash_wordwr_ctrl`

## Requirements
- R1: Within a session, the first accepted byte of a pair becomes bits 7:0 and the second becomes bits 15:8 of the programmed word.
- R2: A program operation starts only when the second byte of a pair is accepted. Accepting the first byte of a pair leaves the busy bit (CTRL bit 1) at 0.
- R3: The busy bit reads 1 for exactly PROG_CYCLES clock cycles after the cycle in which the second byte was accepted. The array holds the new word once busy falls.
- R4: A read of the array (`flash_rd_en`) in a cycle where busy is 1 sets the violation bit (CTRL bit 2). A read while busy is 0 leaves it unchanged. Writing CTRL with bit 2 set clears it.
- R5: The word address is formed as follows: ADDR_HI (register 2) bits 5:1 give the page number, and ADDR_HI bit 0 followed by ADDR_LO (register 1) bits 7:0 give the word within a 512-word page. The array index is page × 512 + word, so the setting 0x05FF reaches index 1535 (page 2, word 511).
- R6: After every programmed word, the 14-bit value {ADDR_HI[5:0], ADDR_LO} increases by one. The increment carries from word 511 into the next page.
- R7: `dma_req` is 1 exactly when a session is open, no program is in progress and the byte count is non-zero. It is 1 in the cycle after WRITE (CTRL bit 0) is set with a non-zero count.
- R8: The byte count (register 4) drops by one per accepted byte. When a program completes and the count is zero, the session closes and CTRL bit 0 reads 0.
- R9: Writing CTRL with bit 0 clear closes the session and discards a held first byte. Data writes outside a session change neither the count nor the address.
- R10: A data write (register 3) while busy is 1 is ignored and does not change the count.
- R11: Setting WRITE while the count is zero leaves the session closed.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register select: 0 CTRL, 1 ADDR_LO, 2 ADDR_HI, 3 DATA, 4 COUNT |
| reg_wdata | input | 8 | Register write data |
| reg_rdata | output | 8 | Read data of the selected register (combinational) |
| dma_req | output | 1 | Data register can take another byte |
| flash_rd_en | input | 1 | Array read strobe |
| flash_rd_addr | input | PAGE_BITS+9 | Array read index (page × 512 + word) |
| flash_rd_data | output | 16 | Read data, valid the cycle after the strobe |

## Verification
A pairing phase that has drifted out of step shows up on the next byte. Busy rises one byte early or late, and the swapped halves appear in the array as soon as busy falls. A wrong program timer changes the length of the busy pulse and moves the `dma_req` edge by the same number of cycles. A wrong address register shows up in the ADDR_LO/ADDR_HI readback right after the program, and in which array word the next program lands. A missed count step keeps `dma_req` high past the last byte, or closes the session one word early.

// File: rtl/fww_pkg.sv
package fww_pkg;

  localparam int WORD_BITS = 9;
  localparam int PAGE_FIELD = 5;

  typedef enum logic [2:0] {
    SEL_CTRL  = 3'd0,
    SEL_ALO   = 3'd1,
    SEL_AHI   = 3'd2,
    SEL_DATA  = 3'd3,
    SEL_COUNT = 3'd4
  } reg_sel_e;

  typedef struct packed {
    logic [PAGE_FIELD-1:0] page;
    logic [WORD_BITS-1:0]  word;
  } faddr_t;

  // Build the target from the two address bytes.
  function automatic faddr_t faddr_from_regs(input logic [7:0] hi, input logic [7:0] lo);
    faddr_t a;
    a.page = hi[5:1];
    a.word = {hi[0], lo};
    return a;
  endfunction

  function automatic logic [7:0] faddr_hi_byte(input faddr_t a);
    return {2'b00, a.page, a.word[8]};
  endfunction

  // Word step with carry into the page field.
  function automatic faddr_t faddr_next(input faddr_t a);
    faddr_t n;
    if (a.word == {WORD_BITS{1'b1}}) begin
      n.word = '0;
      n.page = a.page + 1'b1;
    end else begin
      n.word = a.word + 1'b1;
      n.page = a.page;
    end
    return n;
  endfunction

  function automatic logic [15:0] pack_word(input logic [7:0] first, input logic [7:0] second);
    return {second, first};
  endfunction

endpackage

// File: rtl/fww_regif.sv
module fww_regif
  import fww_pkg::*;
#(
  parameter int CNT_W = 8
) (
  input  logic             reg_we,
  input  logic [2:0]       reg_addr,
  input  logic             active,
  input  logic             busy,
  input  logic             viol,
  input  faddr_t           faddr,
  input  logic [CNT_W-1:0] count,
  output logic             ctrl_we,
  output logic             alo_we,
  output logic             ahi_we,
  output logic             data_we,
  output logic             cnt_we,
  output logic [7:0]       reg_rdata
);

  reg_sel_e sel;
  assign sel = reg_sel_e'(reg_addr);

  always_comb begin
    ctrl_we = 1'b0;
    alo_we  = 1'b0;
    ahi_we  = 1'b0;
    data_we = 1'b0;
    cnt_we  = 1'b0;
    if (reg_we) begin
      case (sel)
        SEL_CTRL:  ctrl_we = 1'b1;
        SEL_ALO:   alo_we  = 1'b1;
        SEL_AHI:   ahi_we  = 1'b1;
        SEL_DATA:  data_we = 1'b1;
        SEL_COUNT: cnt_we  = 1'b1;
        default: ;
      endcase
    end
  end

  always_comb begin
    reg_rdata = '0;
    case (sel)
      SEL_CTRL:  reg_rdata = {5'b0, viol, busy, active};
      SEL_ALO:   reg_rdata = faddr.word[7:0];
      SEL_AHI:   reg_rdata = faddr_hi_byte(faddr);
      SEL_COUNT: reg_rdata = 8'(count);
      default:   reg_rdata = '0;
    endcase
  end

endmodule

// File: rtl/fww_seq.sv
module fww_seq
  import fww_pkg::*;
#(
  parameter int PROG_CYCLES = 6,
  parameter int CNT_W       = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             ctrl_we,
  input  logic             alo_we,
  input  logic             ahi_we,
  input  logic             data_we,
  input  logic             cnt_we,
  input  logic [7:0]       wdata,
  input  logic             flash_rd_en,
  output logic             active,
  output logic             busy,
  output logic             viol,
  output faddr_t           faddr,
  output logic [CNT_W-1:0] count,
  output logic             dma_req,
  output logic             byte_accept,
  output logic             prog_start,
  output logic             prog_done,
  output logic [15:0]      prog_data
);

  localparam int TW = (PROG_CYCLES < 2) ? 1 : $clog2(PROG_CYCLES);
  localparam logic [TW-1:0] T_LOAD = TW'(PROG_CYCLES - 1);

  logic [TW-1:0] timer;
  logic [7:0]    lo_byte;
  logic          lo_held;
  logic          cnt_nz;

  assign cnt_nz      = (count != '0);
  assign byte_accept = data_we && active && !busy && cnt_nz;
  assign prog_start  = byte_accept && lo_held;
  assign prog_done   = busy && (timer == '0);
  assign dma_req     = active && !busy && cnt_nz;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      active    <= 1'b0;
      busy      <= 1'b0;
      viol      <= 1'b0;
      faddr     <= '0;
      count     <= '0;
      timer     <= '0;
      lo_byte   <= '0;
      lo_held   <= 1'b0;
      prog_data <= '0;
    end else begin
      // program timer and completion
      if (busy) begin
        if (prog_done) begin
          busy  <= 1'b0;
          faddr <= faddr_next(faddr);
          if (!cnt_nz) active <= 1'b0;
        end else begin
          timer <= timer - 1'b1;
        end
      end

      // byte intake and pairing
      if (byte_accept) begin
        count <= count - 1'b1;
        if (lo_held) begin
          lo_held   <= 1'b0;
          prog_data <= pack_word(lo_byte, wdata);
          busy      <= 1'b1;
          timer     <= T_LOAD;
        end else begin
          lo_byte <= wdata;
          lo_held <= 1'b1;
        end
      end

      // control register
      if (ctrl_we) begin
        if (wdata[0]) begin
          if (!active && cnt_nz) begin
            active  <= 1'b1;
            lo_held <= 1'b0;
          end
        end else begin
          active  <= 1'b0;
          lo_held <= 1'b0;
        end
        if (wdata[2]) viol <= 1'b0;
      end
      if (flash_rd_en && busy) viol <= 1'b1;

      // address and count set-up
      if (alo_we && !busy) faddr.word[7:0] <= wdata;
      if (ahi_we && !busy) faddr <= faddr_from_regs(wdata, faddr.word[7:0]);
      if (cnt_we && !active) count <= CNT_W'(wdata);
    end
  end

endmodule

// File: rtl/fww_flash_model.sv
module fww_flash_model
  import fww_pkg::*;
#(
  parameter int PAGE_BITS = 2,
  localparam int AW = PAGE_BITS + WORD_BITS
) (
  input  logic          clk,
  input  logic          prog_we,
  input  faddr_t        prog_addr,
  input  logic [15:0]   prog_data,
  input  logic          rd_en,
  input  logic [AW-1:0] rd_addr,
  output logic [15:0]   rd_data
);

  localparam int DEPTH = 1 << AW;

  logic [15:0] mem [DEPTH];
  logic [AW-1:0] widx;

  assign widx = {prog_addr.page[PAGE_BITS-1:0], prog_addr.word};

  always_ff @(posedge clk) begin
    if (prog_we) mem[widx] <= prog_data;
    if (rd_en) rd_data <= mem[rd_addr];
  end

endmodule

// File: rtl/flash_wordwr_ctrl.sv
module flash_wordwr_ctrl
  import fww_pkg::*;
#(
  parameter int PROG_CYCLES = 6,
  parameter int PAGE_BITS   = 2,
  parameter int CNT_W       = 8,
  localparam int AW = PAGE_BITS + WORD_BITS
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          reg_we,
  input  logic [2:0]    reg_addr,
  input  logic [7:0]    reg_wdata,
  output logic [7:0]    reg_rdata,
  output logic          dma_req,
  input  logic          flash_rd_en,
  input  logic [AW-1:0] flash_rd_addr,
  output logic [15:0]   flash_rd_data
);

  logic             ctrl_we, alo_we, ahi_we, data_we, cnt_we;
  logic             active, busy, viol;
  faddr_t           faddr;
  logic [CNT_W-1:0] count;
  logic             byte_accept, prog_start, prog_done;
  logic [15:0]      prog_data;

  fww_regif #(.CNT_W(CNT_W)) u_regif (
    .reg_we    (reg_we),
    .reg_addr  (reg_addr),
    .active    (active),
    .busy      (busy),
    .viol      (viol),
    .faddr     (faddr),
    .count     (count),
    .ctrl_we   (ctrl_we),
    .alo_we    (alo_we),
    .ahi_we    (ahi_we),
    .data_we   (data_we),
    .cnt_we    (cnt_we),
    .reg_rdata (reg_rdata)
  );

  fww_seq #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_seq (
    .clk         (clk),
    .rst_n       (rst_n),
    .ctrl_we     (ctrl_we),
    .alo_we      (alo_we),
    .ahi_we      (ahi_we),
    .data_we     (data_we),
    .cnt_we      (cnt_we),
    .wdata       (reg_wdata),
    .flash_rd_en (flash_rd_en),
    .active      (active),
    .busy        (busy),
    .viol        (viol),
    .faddr       (faddr),
    .count       (count),
    .dma_req     (dma_req),
    .byte_accept (byte_accept),
    .prog_start  (prog_start),
    .prog_done   (prog_done),
    .prog_data   (prog_data)
  );

  fww_flash_model #(.PAGE_BITS(PAGE_BITS)) u_flash (
    .clk       (clk),
    .prog_we   (prog_done),
    .prog_addr (faddr),
    .prog_data (prog_data),
    .rd_en     (flash_rd_en),
    .rd_addr   (flash_rd_addr),
    .rd_data   (flash_rd_data)
  );

endmodule

// File: rtl/fww_checker.sv
module fww_checker
  import fww_pkg::*;
#(
  parameter int PROG_CYCLES = 6,
  parameter int CNT_W       = 8
) (
  input logic             clk,
  input logic             rst_n,
  input logic             reg_we,
  input logic [2:0]       reg_addr,
  input logic             flash_rd_en,
  input logic             dma_req,
  input logic             active,
  input logic             busy,
  input logic             viol,
  input faddr_t           faddr,
  input logic [CNT_W-1:0] count,
  input logic             prog_done
);

  logic [15:0] busy_run;

  always_ff @(posedge clk) begin
    if (!rst_n) busy_run <= '0;
    else if (busy) busy_run <= busy_run + 1'b1;
    else busy_run <= '0;
  end

  assert_busy_from_data_R2: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(busy) |-> $past(reg_we && reg_addr == 3'd3));

  assert_busy_bound_R3: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> (busy_run < 16'(PROG_CYCLES)));

  assert_busy_span_R3: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(busy) |-> ($past(busy_run) == 16'(PROG_CYCLES - 1)));

  assert_viol_set_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (flash_rd_en && busy) |=> viol);

  assert_addr_step_R6: assert property (@(posedge clk) disable iff (!rst_n)
    prog_done |=> (faddr == faddr_next($past(faddr))));

  assert_req_quiet_busy_R7: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !dma_req);

  assert_req_quiet_empty_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (count == '0) |-> !dma_req);

  assert_session_close_R8: assert property (@(posedge clk) disable iff (!rst_n)
    (prog_done && count == '0) |=> !active);

endmodule

bind flash_wordwr_ctrl fww_checker #(.PROG_CYCLES(PROG_CYCLES), .CNT_W(CNT_W)) u_chk (
  .clk         (clk),
  .rst_n       (rst_n),
  .reg_we      (reg_we),
  .reg_addr    (reg_addr),
  .flash_rd_en (flash_rd_en),
  .dma_req     (dma_req),
  .active      (active),
  .busy        (busy),
  .viol        (viol),
  .faddr       (faddr),
  .count       (count),
  .prog_done   (prog_done)
);

// File: tb/flash_wordwr_ctrl_tb.sv
module flash_wordwr_ctrl_tb;

  localparam int N  = 6;
  localparam int AW = 11;

  localparam logic [2:0] A_CTRL = 3'd0, A_ALO = 3'd1, A_AHI = 3'd2, A_DATA = 3'd3, A_CNT = 3'd4;

  // {addr_hi, addr_lo, first byte, second byte}
  localparam logic [31:0] VEC [5] = '{
    32'h05_FF_3C_A7,
    32'h00_00_11_22,
    32'h01_2A_FE_01,
    32'h07_FF_55_AA,
    32'h02_10_80_7F
  };

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic reg_we = 1'b0;
  logic [2:0] reg_addr = '0;
  logic [7:0] reg_wdata = '0;
  logic [7:0] reg_rdata;
  logic dma_req;
  logic flash_rd_en = 1'b0;
  logic [AW-1:0] flash_rd_addr = '0;
  logic [15:0] flash_rd_data;

  int checks = 0;
  int fails = 0;
  bit done = 1'b0;

  always #4 clk = ~clk;

  flash_wordwr_ctrl #(.PROG_CYCLES(N), .PAGE_BITS(2), .CNT_W(8)) u_dut (
    .clk(clk), .rst_n(rst_n), .reg_we(reg_we), .reg_addr(reg_addr),
    .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .dma_req(dma_req),
    .flash_rd_en(flash_rd_en), .flash_rd_addr(flash_rd_addr),
    .flash_rd_data(flash_rd_data)
  );

  task automatic chk(input string tag, input logic [31:0] got, input logic [31:0] exp);
    checks++;
    if (got !== exp) begin
      fails++;
      $display("FAIL %s got=%0h exp=%0h", tag, got, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    @(negedge clk);
    reg_we = 1'b1; reg_addr = a; reg_wdata = d;
    @(negedge clk);
    reg_we = 1'b0;
  endtask

  task automatic rdr(input logic [2:0] a, output logic [7:0] v);
    reg_addr = a;
    #1;
    v = reg_rdata;
  endtask

  task automatic frd(input int idx, output logic [15:0] v);
    @(negedge clk);
    flash_rd_en = 1'b1; flash_rd_addr = AW'(idx);
    @(negedge clk);
    flash_rd_en = 1'b0;
    v = flash_rd_data;
  endtask

  function automatic int bench_index(input logic [7:0] hi, input logic [7:0] lo);
    int page, word;
    page = int'(hi[5:1]);
    word = int'(hi[0]) * 256 + int'(lo);
    return (page % 4) * 512 + word;
  endfunction

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      fails++;
      checks++;
      $display("FAIL watchdog expired");
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
    end
  end

  initial begin
    logic [7:0] v;
    logic [15:0] w;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);

    // reset state
    rdr(A_CTRL, v); chk("reset ctrl", v, 0);
    chk("reset dma_req R7", dma_req, 0);
    rdr(A_CNT, v); chk("reset count R8", v, 0);

    // table walk
    for (int i = 0; i < 5; i++) begin
      logic [7:0] hi, lo, b0, b1;
      logic [13:0] nxt;
      {hi, lo, b0, b1} = VEC[i];
      wr(A_AHI, hi);
      wr(A_ALO, lo);
      wr(A_CNT, 8'd2);
      wr(A_CTRL, 8'h01);
      chk("dma_req after WRITE R7", dma_req, 1);
      wr(A_DATA, b0);
      rdr(A_CTRL, v); chk("busy low after first byte R2", v[1], 0);
      chk("dma_req held for second byte R7", dma_req, 1);
      wr(A_DATA, b1);
      rdr(A_CTRL, v); chk("busy after second byte R2", v[1], 1);
      chk("dma_req low while busy R7", dma_req, 0);
      repeat (N - 1) @(negedge clk);
      rdr(A_CTRL, v); chk("busy still high at cycle N R3", v[1], 1);
      @(negedge clk);
      rdr(A_CTRL, v); chk("busy low after N R3", v[1], 0);
      chk("session closed at zero count R8", v[0], 0);
      nxt = {hi[5:0], lo} + 14'd1;
      rdr(A_ALO, v); chk("addr lo step R6", v, {24'd0, nxt[7:0]});
      rdr(A_AHI, v); chk("addr hi step R6", v, {26'd0, nxt[13:8]});
      frd(bench_index(hi, lo), w);
      chk("word packing R1", w, {b1, b0});
    end

    // stated example: 0x05FF lands at index 1535
    frd(1535, w); chk("page 2 word 511 index R5", w, 16'hA73C);

    // zero count start
    wr(A_CNT, 8'd0);
    wr(A_CTRL, 8'h01);
    rdr(A_CTRL, v); chk("zero count keeps session closed R11", v[0], 0);
    chk("zero count no dma_req R11", dma_req, 0);

    // DMA paced multi-word session with a write during busy
    wr(A_AHI, 8'h00); wr(A_ALO, 8'h40);
    wr(A_CNT, 8'd4);
    wr(A_CTRL, 8'h01);
    wr(A_DATA, 8'h11);
    wr(A_DATA, 8'h22);
    wr(A_DATA, 8'h99);
    rdr(A_CNT, v); chk("write during busy ignored R10", v, 2);
    while (!dma_req) @(negedge clk);
    wr(A_DATA, 8'h33);
    while (!dma_req) @(negedge clk);
    wr(A_DATA, 8'h44);
    rdr(A_CTRL, v); chk("busy on last pair R2", v[1], 1);
    // read during busy
    frd(0, w);
    rdr(A_CTRL, v); chk("read while busy flags violation R4", v[2], 1);
    repeat (N + 1) @(negedge clk);
    rdr(A_CTRL, v); chk("multi-word session closed R8", v[0], 0);
    frd(64, w); chk("first word of session R1", w, 16'h2211);
    frd(65, w); chk("second word skips busy byte R10", w, 16'h4433);
    rdr(A_CTRL, v); chk("violation sticky R4", v[2], 1);
    wr(A_CTRL, 8'h04);
    rdr(A_CTRL, v); chk("violation cleared R4", v[2], 0);
    frd(64, w);
    rdr(A_CTRL, v); chk("idle read no violation R4", v[2], 0);

    // abort with a held byte, then data outside a session
    wr(A_AHI, 8'h00); wr(A_ALO, 8'h80);
    wr(A_CNT, 8'd2);
    wr(A_CTRL, 8'h01);
    wr(A_DATA, 8'hEE);
    wr(A_CTRL, 8'h00);
    rdr(A_CTRL, v); chk("WRITE clear closes session R9", v[0], 0);
    chk("no dma_req after abort R9", dma_req, 0);
    wr(A_DATA, 8'hDD);
    rdr(A_CNT, v); chk("data outside session keeps count R9", v, 1);
    rdr(A_ALO, v); chk("data outside session keeps addr R9", v, 8'h80);
    wr(A_CNT, 8'd2);
    wr(A_CTRL, 8'h01);
    wr(A_DATA, 8'h5A);
    wr(A_DATA, 8'hC3);
    repeat (N + 1) @(negedge clk);
    frd(128, w); chk("held byte discarded R9", w, 16'hC35A);

    // odd count: request drops when count reaches zero with no pair
    wr(A_CNT, 8'd1);
    wr(A_CTRL, 8'h01);
    wr(A_DATA, 8'h42);
    chk("odd tail no dma_req R7", dma_req, 0);
    rdr(A_CTRL, v); chk("odd tail no program R2", v[1], 0);
    wr(A_CTRL, 8'h00);

    done = 1'b1;
    $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
    $finish;
  end

endmodule